// File: doc/BRIEF.md
# Vectored Interrupt Data Port

This block sits on a processor's system bus and takes in data words from a sensing circuit. Each captured word is held in a bus-readable register and raises a single shared interrupt request. When the processor answers with an interrupt acknowledge, the block puts its own interrupt vector on the read-data bus, so the processor can jump straight to the matching service routine.

The service routine reads the data register, and that read retires the request. No separate status write is needed. The vector is held in a register that software can rewrite. It resets to 16.

A word that arrives while the request is still pending replaces the stored word and sets a sticky overrun flag. A read of the status register clears that flag. The read-data path is a muxed bus: the block drives a word together with a drive-enable, and returns zero whenever it is not selected.

If an acknowledge arrives while this block has no pending request, the block stays silent. Several such blocks can therefore share one interrupt line.

Top module: `vint_port`

## Requirements
- R1: After reset, `irq` is 0, `bus_rdata_en` is 0 on an idle bus, and the vector register reads 16.
- R2: A cycle with `in_valid` high stores `in_data` in the data register (address `DATA_ADDR`, default 0x8000), and `irq` is 1 from the next cycle.
- R3: While `irq_ack` is high and a request is pending, `bus_rdata` equals the vector register and `bus_rdata_en` is 1 in the same cycle. This takes priority over any bus read.
- R4: While `irq_ack` is high and no request is pending, the block returns `bus_rdata_en` = 0 and `bus_rdata` = 0.
- R5: A bus read of the data register returns the stored word in the same cycle, and `irq` is 0 from the next cycle.
- R6: A bus write to `VEC_ADDR` (default 0x8006) loads the vector register. Both a read of `VEC_ADDR` and the next acknowledge return the new value.
- R7: A new word that arrives while a request is pending overwrites the data register and sets the overrun flag. The status register at `STAT_ADDR` (default 0x8004) holds pending in bit 0 and overrun in bit 1. Reading it returns the flags in force before the read and clears overrun from the next cycle.
- R8: With no read and no acknowledge, or on a read of an unmapped address, `bus_rdata_en` is 0 and `bus_rdata` is 0.
- R9: If a word arrives in the same cycle as a data-register read, the read returns the old word, `irq` stays 1, and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sensing side: word present this cycle |
| in_data | input | DW | Sensing side: data word |
| bus_addr | input | AW | Bus address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Muxed read data, zero when not driving |
| bus_rdata_en | output | 1 | Block drives the read-data bus |
| irq | output | 1 | Interrupt request (pending flag) |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |

## Verification
If the pending flag is wrong, the error appears on `irq` one cycle after the capture or data read that should have changed it. It also changes whether an acknowledge is answered in that same cycle.

A corrupted vector register shows up on the very next acknowledge or `VEC_ADDR` read. A wrong overrun flag is visible on the next status read. The same-cycle capture/read collision is exercised on purpose, because a wrong set/clear priority would drop a request with no other symptom.

// File: rtl/vint_pkg.sv
package vint_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_VEC  = 2'd3
  } rd_sel_e;

  localparam int STAT_PEND_BIT = 0;
  localparam int STAT_OVR_BIT  = 1;
endpackage

// File: rtl/vint_rst_sync.sv
module vint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vint_capture.sv
module vint_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          data_rd,
  input  logic          stat_rd,
  output logic [DW-1:0] data_q,
  output logic          pend_q,
  output logic          ovr_q
);
  logic [DW-1:0] data_d;
  logic          data_en;
  logic          pend_d;
  logic          ovr_d;
  logic          ovr_hit;

  // Next-state: a capture wins over a same-cycle clear (R9)
  always_comb begin
    data_en = in_valid;
    data_d  = in_data;
    ovr_hit = in_valid && pend_q && !data_rd;
    pend_d  = pend_q;
    if (data_rd)  pend_d = 1'b0;
    if (in_valid) pend_d = 1'b1;
    ovr_d = ovr_q;
    if (stat_rd) ovr_d = 1'b0;
    if (ovr_hit) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (pend_q && data_q == $past(in_data)));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !in_valid) |=> !pend_q);

  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pend_q && !data_rd) |=> ovr_q);

  a_r7_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(in_valid && pend_q && !data_rd)) |=> !ovr_q);

  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && data_rd && !ovr_q && !stat_rd) |=> (pend_q && !ovr_q));
endmodule

// File: rtl/vint_regs.sv
module vint_regs
  import vint_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [AW-1:0] DATA_ADDR = 16'h8000,
  parameter logic [AW-1:0] STAT_ADDR = 16'h8004,
  parameter logic [AW-1:0] VEC_ADDR  = 16'h8006,
  parameter logic [DW-1:0] VEC_RESET = 8'd16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic          data_rd,
  output logic          stat_rd,
  output rd_sel_e       rd_sel,
  output logic [DW-1:0] vec_q
);
  logic          hit_data;
  logic          hit_stat;
  logic          hit_vec;
  logic          vec_en;
  logic [DW-1:0] vec_d;

  always_comb begin
    hit_data = (bus_addr == DATA_ADDR);
    hit_stat = (bus_addr == STAT_ADDR);
    hit_vec  = (bus_addr == VEC_ADDR);
    data_rd  = bus_rd && hit_data;
    stat_rd  = bus_rd && hit_stat;
    rd_sel   = SEL_NONE;
    if (bus_rd) begin
      if (hit_data)     rd_sel = SEL_DATA;
      else if (hit_stat) rd_sel = SEL_STAT;
      else if (hit_vec)  rd_sel = SEL_VEC;
    end
    vec_en = bus_wr && hit_vec;
    vec_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= VEC_RESET;
    else if (vec_en) vec_q <= vec_d;
  end

  a_r6_vec_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == VEC_ADDR) |=> (vec_q == $past(bus_wdata)));

  a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == VEC_ADDR) |=> $stable(vec_q));
endmodule

// File: rtl/vint_rd_mux.sv
module vint_rd_mux
  import vint_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          irq_ack,
  input  logic          pend,
  input  logic          ovr,
  input  rd_sel_e       rd_sel,
  input  logic [DW-1:0] vec,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] rdata,
  output logic          rdata_en
);
  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_PEND_BIT] = pend;
    stat_word[STAT_OVR_BIT]  = ovr;
    rdata    = '0;
    rdata_en = 1'b0;
    if (irq_ack && pend) begin
      rdata    = vec;
      rdata_en = 1'b1;
    end else begin
      case (rd_sel)
        SEL_DATA: begin rdata = data;      rdata_en = 1'b1; end
        SEL_STAT: begin rdata = stat_word; rdata_en = 1'b1; end
        SEL_VEC:  begin rdata = vec;       rdata_en = 1'b1; end
        default:  begin rdata = '0;        rdata_en = 1'b0; end
      endcase
    end
  end

  always_comb begin
    a_r8_zero_when_idle: assert (rdata_en || rdata == '0);
  end
endmodule

// File: rtl/vint_port.sv
module vint_port
  import vint_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [AW-1:0] DATA_ADDR = 16'h8000,
  parameter logic [AW-1:0] STAT_ADDR = 16'h8004,
  parameter logic [AW-1:0] VEC_ADDR  = 16'h8006,
  parameter logic [DW-1:0] VEC_RESET = 8'd16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rdata_en,
  output logic          irq,
  input  logic          irq_ack
);
  logic          rst_n_s;
  logic          data_rd;
  logic          stat_rd;
  rd_sel_e       rd_sel;
  logic [DW-1:0] vec_q;
  logic [DW-1:0] data_q;
  logic          pend_q;
  logic          ovr_q;

  vint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  vint_regs #(
    .AW(AW), .DW(DW), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR),
    .VEC_ADDR(VEC_ADDR), .VEC_RESET(VEC_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .data_rd   (data_rd),
    .stat_rd   (stat_rd),
    .rd_sel    (rd_sel),
    .vec_q     (vec_q)
  );

  vint_capture #(.DW(DW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (in_valid),
    .in_data  (in_data),
    .data_rd  (data_rd),
    .stat_rd  (stat_rd),
    .data_q   (data_q),
    .pend_q   (pend_q),
    .ovr_q    (ovr_q)
  );

  vint_rd_mux #(.DW(DW)) u_mux (
    .irq_ack  (irq_ack),
    .pend     (pend_q),
    .ovr      (ovr_q),
    .rd_sel   (rd_sel),
    .vec      (vec_q),
    .data     (data_q),
    .rdata    (bus_rdata),
    .rdata_en (bus_rdata_en)
  );

  assign irq = pend_q;

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n_s |-> (!irq && !(bus_rdata_en && !bus_rd && !irq_ack)));

  a_r3_ack_vector: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_ack && irq) |-> (bus_rdata_en && bus_rdata == vec_q));

  a_r4_ack_silent: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_ack && !irq && !bus_rd) |-> !bus_rdata_en);

  a_r8_idle_bus: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!bus_rd && !irq_ack) |-> (!bus_rdata_en && bus_rdata == '0));
endmodule

// File: tb/tb_vint_port.sv
module tb_vint_port;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_DATA = 16'h8000;
  localparam logic [AW-1:0] A_STAT = 16'h8004;
  localparam logic [AW-1:0] A_VEC  = 16'h8006;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rdata_en;
  logic          irq;
  logic          irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  vint_port dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_en(bus_rdata_en), .irq(irq), .irq_ack(irq_ack)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    @(posedge clk); #1; in_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output int d, output int en);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2; d = bus_rdata; en = bus_rdata_en;
    @(posedge clk); #1; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] w);
    @(negedge clk); bus_addr = a; bus_wdata = w; bus_wr = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0;
  endtask

  task automatic ack(output int d, output int en);
    @(negedge clk); irq_ack = 1'b1;
    #2; d = bus_rdata; en = bus_rdata_en;
    @(posedge clk); #1; irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    int d, en;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 idle en", bus_rdata_en, 0);
    rd(A_VEC, d, en);
    chk("R1 vector reset", d, 16);
  endtask

  task automatic t_capture();
    int d, en;
    push(8'hA5);
    chk("R2 irq raised", irq, 1);
    ack(d, en);
    chk("R3 ack en", en, 1);
    chk("R3 ack vector", d, 16);
    rd(A_DATA, d, en);
    chk("R2 data word", d, 8'hA5);
    chk("R5 irq cleared", irq, 0);
  endtask

  task automatic t_spurious_ack();
    int d, en;
    ack(d, en);
    chk("R4 no drive", en, 0);
    chk("R4 zero data", d, 0);
  endtask

  task automatic t_vector();
    int d, en;
    wr(A_VEC, 8'h3C);
    rd(A_VEC, d, en);
    chk("R6 vector readback", d, 8'h3C);
    push(8'h11);
    ack(d, en);
    chk("R6 new vector on ack", d, 8'h3C);
    rd(A_DATA, d, en);
    chk("R6 data", d, 8'h11);
  endtask

  task automatic t_overrun();
    int d, en;
    push(8'h22);
    push(8'h33);
    rd(A_STAT, d, en);
    chk("R7 status pend+ovr", d, 3);
    rd(A_STAT, d, en);
    chk("R7 ovr cleared", d, 1);
    rd(A_DATA, d, en);
    chk("R7 overwritten word", d, 8'h33);
    rd(A_STAT, d, en);
    chk("R7 status empty", d, 0);
  endtask

  task automatic t_idle();
    int d, en;
    rd(16'h1234, d, en);
    chk("R8 unmapped en", en, 0);
    chk("R8 unmapped data", d, 0);
    @(negedge clk); #2;
    chk("R8 idle en", bus_rdata_en, 0);
    chk("R8 idle data", bus_rdata, 0);
  endtask

  task automatic t_collision();
    int d, en;
    push(8'h44);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h55; bus_addr = A_DATA; bus_rd = 1'b1;
    #2; d = bus_rdata;
    @(posedge clk); #1; in_valid = 1'b0; bus_rd = 1'b0;
    chk("R9 old word read", d, 8'h44);
    chk("R9 irq held", irq, 1);
    rd(A_STAT, d, en);
    chk("R9 no overrun", d, 1);
    rd(A_DATA, d, en);
    chk("R9 new word", d, 8'h55);
    chk("R9 irq cleared", irq, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_capture();
    t_spurious_ack();
    t_vector();
    t_overrun();
    t_idle();
    t_collision();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule